// File: doc/BRIEF.md
# Multi-Stage Conversion Sequencer

This block steps a shared converter through a repeating run of up to twelve measurement stages. Each stage owns one entry of a small configuration file that holds an input-select code and two offset trims. When a sequence starts, the block loads stage 0's entry into a holding register. It presents that entry to the converter, issues a one-cycle start, and waits for the converter's done strobe. It then stores the returned sample in that stage's result slot and moves on to the next stage.

The run always begins at stage 0 and ends at a programmed last stage. A last-stage value above 11 is treated as 11. When the final stage finishes, a one-cycle completion pulse is raised. With continuous mode set, the block starts over at stage 0 without a new start request. A separate 12-bit calibration-enable mask travels alongside the sequence: each stage's bit is presented to the converter during that stage. The mask has no effect on how many stages run. Results are read back through an asynchronous read port.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, `conv_start`, `seq_done` and `conv_stage` are 0 and every result slot reads 0.
- R2: A sequence begins at stage 0, and each following conversion uses the next stage number, one higher than the last.
- R3: With `ctrl_last` = L (L ≤ 11), a sequence performs exactly L+1 conversions, on stages 0 to L. For example, L = 5 gives six stages.
- R4: A `ctrl_last` value of 12 to 15 is clamped to 11, giving twelve conversions.
- R5: While a stage converts, the outputs show that stage's configuration word. The word is laid out as `conv_mux` in bits [7:0], `conv_pos_ofs` in bits [13:8] and `conv_neg_ofs` in bits [19:14].
- R6: The stage configuration is latched one cycle before `conv_start`. It stays unchanged until `conv_done`, even if that configuration entry is rewritten meanwhile. The rewritten value applies to the next conversion of that stage. `conv_start` lasts one cycle.
- R7: On `conv_done`, `conv_data` is stored in the result slot of the current stage. Slots of stages that do not run keep their previous contents.
- R8: `seq_done` is high for exactly one cycle, in the cycle after the last stage's `conv_done`.
- R9: With `ctrl_cont` = 1 when the last stage completes, a new sequence starts at stage 0 without `seq_start`. With `ctrl_cont` = 0, the block goes idle and issues no further `conv_start`.
- R10: `conv_cal` equals the `cal_en_mask` bit indexed by the converting stage. The mask does not change the number of stages.
- R11: A `seq_start` pulse arriving while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_start | input | 1 | Start a sequence when idle |
| ctrl_last | input | 4 | Last stage number of a sequence |
| ctrl_cont | input | 1 | Continuous restart enable |
| cal_en_mask | input | 12 | Per-stage calibration enable |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 4 | Configuration entry to write |
| cfg_wr_data | input | 20 | Configuration word |
| conv_start | output | 1 | Start pulse to the converter |
| conv_done | input | 1 | Converter finished |
| conv_data | input | 16 | Converter sample |
| conv_stage | output | 4 | Stage currently in progress |
| conv_mux | output | 8 | Input-select code for the converter |
| conv_pos_ofs | output | 6 | Positive offset trim |
| conv_neg_ofs | output | 6 | Negative offset trim |
| conv_cal | output | 1 | Calibration enable of current stage |
| seq_done | output | 1 | One-cycle sequence complete pulse |
| rd_addr | input | 4 | Result slot to read |
| rd_data | output | 16 | Result slot contents |

## Verification
The bench focuses on the corners where a sequencer typically fails:
- Last-stage value 0, which gives a single-stage run. A design with an off-by-one end test would run two stages or wrap.
- Last-stage values of 11 and 15. A missing clamp would step into nonexistent stages and never raise completion.
- A configuration rewrite while a conversion is pending. A design that reads the configuration file directly would change the mux code mid-conversion.
- A stray start request in mid-sequence. A design that honours it would jump back to stage 0.
- Clearing continuous mode. A design that kept running would issue further starts after the final completion pulse.

// File: rtl/convseq_pkg.sv
// Package: shared state encoding for the conversion sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package convseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_START = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/convseq_cfg_file.sv
// Per-stage configuration register file with one write port and one
// asynchronous read port. Assumes writes to addresses >= STAGES are dropped.
module convseq_cfg_file #(
    parameter int STAGES = 12,
    parameter int CFG_W  = 20,
    localparam int SW    = $clog2(STAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SW-1:0]    waddr,
    input  logic [CFG_W-1:0] wdata,
    input  logic [SW-1:0]    raddr,
    output logic [CFG_W-1:0] rdata
);
    logic [CFG_W-1:0] mem [STAGES];

    // Store a configuration word into the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) mem[i] <= '0;
        end else if (we && (int'(waddr) < STAGES)) begin
            mem[waddr] <= wdata;
        end
    end

    // Read the entry for the stage being loaded.
    always_comb rdata = (int'(raddr) < STAGES) ? mem[raddr] : '0;
endmodule

// File: rtl/convseq_result_file.sv
// Per-stage result storage: written on converter completion, read
// asynchronously. Assumes out-of-range read addresses return zero.
module convseq_result_file #(
    parameter int STAGES = 12,
    parameter int DATA_W = 16,
    localparam int SW    = $clog2(STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] res [STAGES];

    // Capture a converter sample into the slot of the current stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) res[i] <= '0;
        end else if (we) begin
            res[waddr] <= wdata;
        end
    end

    // Present the requested slot.
    always_comb rdata = (int'(raddr) < STAGES) ? res[raddr] : '0;
endmodule

// File: rtl/convseq_fsm.sv
// Sequence controller: walks stages 0..last, handshakes with the
// converter, pulses completion and optionally restarts.
// Assumes STAGES <= 16 so the 4-bit last-stage field covers every stage.
module convseq_fsm
    import convseq_pkg::*;
#(
    parameter int STAGES = 12,
    localparam int SW    = $clog2(STAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seq_start,
    input  logic [3:0]    last_field,
    input  logic          cont_en,
    input  logic          conv_done,
    output logic [SW-1:0] stage,
    output logic [SW-1:0] last_q,
    output logic          load_en,
    output logic          conv_start,
    output logic          waiting,
    output logic          busy,
    output logic          res_we,
    output logic          seq_done
);
    localparam logic [3:0] LAST_MAX = 4'(STAGES - 1);

    seq_state_t state;

    function automatic logic [SW-1:0] clamp_last(input logic [3:0] f);
        return (f > LAST_MAX) ? SW'(LAST_MAX) : SW'(f);
    endfunction

    // Advance through load, start and wait for each stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            stage    <= '0;
            last_q   <= '0;
            seq_done <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            unique case (state)
                ST_IDLE: if (seq_start) begin
                    stage  <= '0;
                    last_q <= clamp_last(last_field);
                    state  <= ST_LOAD;
                end
                ST_LOAD:  state <= ST_START;
                ST_START: state <= ST_WAIT;
                ST_WAIT: if (conv_done) begin
                    if (stage == last_q) begin
                        seq_done <= 1'b1;
                        stage    <= '0;
                        if (cont_en) begin
                            last_q <= clamp_last(last_field);
                            state  <= ST_LOAD;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end else begin
                        stage <= stage + SW'(1);
                        state <= ST_LOAD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode handshake and control strobes from the state.
    always_comb begin
        load_en    = (state == ST_LOAD);
        conv_start = (state == ST_START);
        waiting    = (state == ST_WAIT);
        busy       = (state != ST_IDLE);
        res_we     = waiting && conv_done;
    end
endmodule

// File: rtl/conv_sequencer.sv
// Top level: configuration file, controller, stage configuration latch
// and result file. Assumes the converter answers each start with one
// conv_done pulse and holds conv_data valid in that cycle.
module conv_sequencer #(
    parameter int STAGES = 12,
    parameter int MUX_W  = 8,
    parameter int OFS_W  = 6,
    parameter int DATA_W = 16,
    localparam int SW    = $clog2(STAGES),
    localparam int CFG_W = MUX_W + 2 * OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_start,
    input  logic [3:0]        ctrl_last,
    input  logic              ctrl_cont,
    input  logic [STAGES-1:0] cal_en_mask,
    input  logic              cfg_wr_en,
    input  logic [SW-1:0]     cfg_wr_addr,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic [SW-1:0]     conv_stage,
    output logic [MUX_W-1:0]  conv_mux,
    output logic [OFS_W-1:0]  conv_pos_ofs,
    output logic [OFS_W-1:0]  conv_neg_ofs,
    output logic              conv_cal,
    output logic              seq_done,
    input  logic [SW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [SW-1:0]    stage, last_q;
    logic             load_en, waiting, busy, res_we;
    logic [CFG_W-1:0] cfg_rdata, cfg_q;
    logic             cal_q;

    convseq_cfg_file #(.STAGES(STAGES), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_wr_en), .waddr(cfg_wr_addr),
        .wdata(cfg_wr_data), .raddr(stage), .rdata(cfg_rdata)
    );

    convseq_fsm #(.STAGES(STAGES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .seq_start(seq_start),
        .last_field(ctrl_last), .cont_en(ctrl_cont), .conv_done(conv_done),
        .stage(stage), .last_q(last_q), .load_en(load_en),
        .conv_start(conv_start), .waiting(waiting), .busy(busy),
        .res_we(res_we), .seq_done(seq_done)
    );

    convseq_result_file #(.STAGES(STAGES), .DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .we(res_we), .waddr(stage),
        .wdata(conv_data), .raddr(rd_addr), .rdata(rd_data)
    );

    // Latch the stage configuration and calibration bit before the start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cal_q <= 1'b0;
        end else if (load_en) begin
            cfg_q <= cfg_rdata;
            cal_q <= cal_en_mask[stage];
        end
    end

    // Split the held configuration onto the converter-facing outputs.
    always_comb begin
        conv_mux     = cfg_q[MUX_W-1:0];
        conv_pos_ofs = cfg_q[MUX_W +: OFS_W];
        conv_neg_ofs = cfg_q[MUX_W+OFS_W +: OFS_W];
        conv_cal     = cal_q;
        conv_stage   = stage;
    end
endmodule

// File: rtl/conv_sequencer_chk.sv
// Checker bound to conv_sequencer: handshake, hold and ordering rules.
// Assumes it sees the top's internal busy/waiting/last_q signals.
module conv_sequencer_chk #(
    parameter int STAGES = 12,
    parameter int MUX_W  = 8,
    parameter int OFS_W  = 6,
    localparam int SW    = $clog2(STAGES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start,
    input logic             conv_done,
    input logic             seq_done,
    input logic             waiting,
    input logic             busy,
    input logic [SW-1:0]    stage,
    input logic [SW-1:0]    last_q,
    input logic [MUX_W-1:0] conv_mux,
    input logic [OFS_W-1:0] conv_pos_ofs,
    input logic [OFS_W-1:0] conv_neg_ofs
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !conv_done) |=> ($stable(conv_mux) && $stable(conv_pos_ofs)
                                     && $stable(conv_neg_ofs))); // R6
    AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (stage <= last_q && int'(last_q) <= STAGES - 1)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done); // R8
    AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (stage == '0)); // R2
    AST_START_NOT_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !waiting); // R6
endmodule

bind conv_sequencer conv_sequencer_chk #(
    .STAGES(STAGES), .MUX_W(MUX_W), .OFS_W(OFS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
    .seq_done(seq_done), .waiting(waiting), .busy(busy), .stage(stage),
    .last_q(last_q), .conv_mux(conv_mux), .conv_pos_ofs(conv_pos_ofs),
    .conv_neg_ofs(conv_neg_ofs)
);

// File: tb/conv_sequencer_tb.sv
// Bench: converter model plus directed and seeded random sequences.
module conv_sequencer_tb;
    localparam int STAGES = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seq_start = 1'b0;
    logic [3:0]  ctrl_last = '0;
    logic        ctrl_cont = 1'b0;
    logic [11:0] cal_en_mask = '0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_addr = '0;
    logic [19:0] cfg_wr_data = '0;
    logic        conv_start;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic [3:0]  conv_stage;
    logic [7:0]  conv_mux;
    logic [5:0]  conv_pos_ofs, conv_neg_ofs;
    logic        conv_cal, seq_done;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;

    conv_sequencer u_dut (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [19:0] mdl_cfg [STAGES];
    logic [15:0] exp_res [STAGES];
    int exp_stage = 0, exp_last = 0, in_seq = 0, n_conv = 0, n_seq = 0;
    bit r6_poke = 0;
    int r6_stage = 0;
    logic [19:0] r6_val = '0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp_f(input int l);
        return (l > STAGES - 1) ? STAGES - 1 : l;
    endfunction

    function automatic int len_f(input int l);
        return clamp_f(l) + 1;
    endfunction

    task automatic write_cfg(input int a, input logic [19:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 4'(a); cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        mdl_cfg[a] = v;
    endtask

    task automatic check_results(input string req);
        for (int i = 0; i < STAGES; i++) begin
            rd_addr = 4'(i);
            #1;
            chk(rd_data == exp_res[i], req, $sformatf("result slot %0d", i),
                rd_data, exp_res[i]);
        end
    endtask

    // Pulse start, then wait for the completion pulse.
    task automatic run_seq(input int last, input string req);
        int base, cnt0;
        @(negedge clk);
        ctrl_last = 4'(last); ctrl_cont = 1'b0;
        exp_last = clamp_f(last); exp_stage = 0; in_seq = 0;
        base = n_seq; cnt0 = n_conv;
        seq_start = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
        for (int t = 0; t < 3000 && n_seq == base; t++) @(negedge clk);
        chk(n_seq == base + 1, req, "sequence completed", n_seq - base, 1);
        chk(n_conv - cnt0 == len_f(last), req, "conversions in sequence",
            n_conv - cnt0, len_f(last));
    endtask

    // Converter model: answers each start, checks the presented stage.
    initial begin
        int st, d;
        logic [19:0] cap;
        logic [15:0] dv;
        forever begin
            @(negedge clk);
            if (rst_n && conv_start) begin
                st = int'(conv_stage);
                chk(st == exp_stage, "R2", "stage order", st, exp_stage);
                chk({conv_neg_ofs, conv_pos_ofs, conv_mux} == mdl_cfg[st], "R5",
                    "stage configuration", {conv_neg_ofs, conv_pos_ofs, conv_mux},
                    mdl_cfg[st]);
                chk(conv_cal == cal_en_mask[st], "R10", "calibration bit",
                    conv_cal, cal_en_mask[st]);
                cap = {conv_neg_ofs, conv_pos_ofs, conv_mux};
                in_seq++;
                d = $urandom_range(1, 4);
                if (r6_poke && st == r6_stage) begin
                    cfg_wr_en = 1'b1; cfg_wr_addr = 4'(st); cfg_wr_data = r6_val;
                    @(negedge clk);
                    cfg_wr_en = 1'b0;
                end
                repeat (d) @(negedge clk);
                chk({conv_neg_ofs, conv_pos_ofs, conv_mux} == cap, "R6",
                    "configuration held until done", {conv_neg_ofs, conv_pos_ofs, conv_mux}, cap);
                if (r6_poke && st == r6_stage) begin
                    mdl_cfg[st] = r6_val;
                    r6_poke = 0;
                end
                dv = 16'($urandom);
                conv_done = 1'b1; conv_data = dv;
                exp_res[st] = dv;
                @(negedge clk);
                conv_done = 1'b0;
                n_conv++;
                chk(seq_done == (st == exp_last), "R8", "completion pulse timing",
                    seq_done, st == exp_last);
                if (st == exp_last) begin
                    chk(in_seq == exp_last + 1, "R3", "stages per sequence",
                        in_seq, exp_last + 1);
                    in_seq = 0;
                    exp_stage = 0;
                end else begin
                    exp_stage = st + 1;
                end
            end
        end
    end

    // Count completion pulses.
    always @(negedge clk) if (rst_n && seq_done) n_seq++;

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int c0, s0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < STAGES; i++) begin
            mdl_cfg[i] = '0; exp_res[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(conv_start == 1'b0, "R1", "conv_start after reset", conv_start, 0);
        chk(seq_done == 1'b0, "R1", "seq_done after reset", seq_done, 0);
        chk(conv_stage == 4'd0, "R1", "stage after reset", conv_stage, 0);
        check_results("R1");

        for (int i = 0; i < STAGES; i++) write_cfg(i, 20'($urandom));
        cal_en_mask = 12'hA5C;

        // R3 / R7: six-stage run leaves upper slots untouched
        run_seq(5, "R3");
        check_results("R7");

        // R3 boundary: single stage
        run_seq(0, "R3");
        check_results("R7");

        // R4: clamp of oversize last-stage values
        run_seq(15, "R4");
        run_seq(12, "R4");
        run_seq(11, "R4");
        check_results("R4");

        // R6: rewrite stage 2 mid-conversion, then confirm it applies next time
        r6_stage = 2; r6_val = 20'hABCDE; r6_poke = 1;
        run_seq(4, "R6");
        chk(r6_poke == 0, "R6", "mid-conversion rewrite performed", r6_poke, 0);
        run_seq(4, "R6");

        // R11: stray start while running is ignored
        @(negedge clk);
        ctrl_last = 4'd3; exp_last = 3; exp_stage = 0; in_seq = 0;
        s0 = n_seq; c0 = n_conv;
        seq_start = 1'b1; @(negedge clk); seq_start = 1'b0;
        for (int t = 0; t < 500 && conv_stage != 4'd2; t++) @(negedge clk);
        seq_start = 1'b1; @(negedge clk); seq_start = 1'b0;
        for (int t = 0; t < 2000 && n_seq == s0; t++) @(negedge clk);
        chk(n_conv - c0 == 4, "R11", "conversions with stray start", n_conv - c0, 4);
        check_results("R11");

        // R10: mask variants do not change the sequence length
        cal_en_mask = 12'hFFF;
        run_seq(7, "R10");
        cal_en_mask = 12'h000;
        run_seq(7, "R10");

        // R9: continuous mode runs several sequences from one start
        @(negedge clk);
        ctrl_last = 4'd2; ctrl_cont = 1'b1; exp_last = 2; exp_stage = 0; in_seq = 0;
        s0 = n_seq;
        seq_start = 1'b1; @(negedge clk); seq_start = 1'b0;
        for (int t = 0; t < 3000 && n_seq < s0 + 3; t++) @(negedge clk);
        chk(n_seq >= s0 + 3, "R9", "sequences from one start", n_seq - s0, 3);
        ctrl_cont = 1'b0;
        repeat (200) @(negedge clk);
        c0 = n_conv;
        repeat (60) @(negedge clk);
        chk(n_conv == c0, "R9", "no starts after leaving continuous mode", n_conv - c0, 0);
        check_results("R9");

        // Random sequences with fresh configuration and mask
        for (int k = 0; k < 10; k++) begin
            int l;
            for (int j = 0; j < 3; j++) write_cfg($urandom_range(0, 11), 20'($urandom));
            cal_en_mask = 12'($urandom);
            l = $urandom_range(0, 15);
            run_seq(l, "R3");
            check_results("R7");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule